// File: doc/BRIEF.md
# Service Request Status Byte Generator

This block forms the 8-bit status byte that an instrument reports to its host controller, and raises a service request line when a selected condition appears. Four summary flags come in from elsewhere in the chip: error pending, response data pending, an extended-event summary and a standard-event summary. A software-written enable mask chooses which of those flags may trigger a request.

The block keeps a master summary bit, which is the OR over the enabled flags, and a latched request bit. The request bit sets on each rising edge of the master summary. It clears when the host performs a serial poll or when the master summary drops. Two read paths share one byte layout and differ only in bit 6. The poll byte carries the latched request bit. The query byte carries the live master summary.

Top module: `srq_status_gen`

## Requirements
- R1: Bits 7, 1 and 0 of both `query_byte_o` and `poll_byte_o` are always 0.
- R2: In both output bytes, in the same cycle as the inputs, bit 2 equals `err_pending_i`, bit 3 equals `ext_sum_i`, bit 4 equals `out_pending_i` and bit 5 equals `std_sum_i`.
- R3: Bit 6 of `query_byte_o` is the master summary. It is 1 in the same cycle exactly when the status bits 2..5 ANDed with the enable mask are nonzero.
- R4: A cycle with `mask_wr_i` high loads `mask_wdata_i` into the enable mask, which shows on `mask_rdata_o` from the next cycle. Bit 6 is forced to 0; all other bits read back as written.
- R5: One cycle after the master summary goes from 0 to 1, the request bit is 1. `srq_o` always equals the request bit.
- R6: One cycle after a cycle with `poll_i` high, the request bit is 0, unless R8 applies.
- R7: One cycle after the master summary is 0, the request bit is 0.
- R8: When `poll_i` is high in the same cycle as a 0-to-1 edge of the master summary, the request bit is 1 in the next cycle.
- R9: Bit 6 of `poll_byte_o` is the request bit as it stands during the poll cycle, before the poll clears it.
- R10: After reset the enable mask is 0 and `srq_o` is 0.
- R11: With a mask bit at 0, the matching status flag changes neither bit 6 of `query_byte_o` nor `srq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pending_i | input | 1 | Error queue not empty |
| out_pending_i | input | 1 | Response queue not empty |
| ext_sum_i | input | 1 | Extended-event summary |
| std_sum_i | input | 1 | Standard-event summary |
| mask_wr_i | input | 1 | Enable-mask write strobe |
| mask_wdata_i | input | 8 | Enable-mask write data |
| mask_rdata_o | output | 8 | Enable-mask readback |
| poll_i | input | 1 | Serial poll strobe, one cycle per poll |
| poll_byte_o | output | 8 | Status byte for serial poll (bit 6 = request bit) |
| query_byte_o | output | 8 | Status byte for status query (bit 6 = master summary) |
| srq_o | output | 1 | Service request to the host |

## Verification
A serial poll can arrive in the same cycle that the master summary rises. The poll then tries to clear the request bit while the edge tries to set it. The bench provokes this by holding the enabled flags low, then raising one together with `poll_i`. It then requires `srq_o` to be 1 in the following cycle. It also polls while the request is already set and no edge occurs, then requires the request bit to be 0 the cycle after. That the poll byte still shows the old request bit during the poll cycle is judged in the same sequence.

// File: rtl/srq_pkg.sv
package srq_pkg;
   localparam int unsigned SB_W     = 8;
   localparam int unsigned POS_ERR  = 2;
   localparam int unsigned POS_EXT  = 3;
   localparam int unsigned POS_OUTQ = 4;
   localparam int unsigned POS_STD  = 5;
   localparam int unsigned POS_SUM  = 6;

   typedef struct packed {
      logic err;
      logic outq;
      logic ext;
      logic std;
   } srq_flags_t;
endpackage

// File: rtl/srq_mask_reg.sv
module srq_mask_reg #(
   parameter int unsigned W        = 8,
   parameter int unsigned HOLE_POS = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   initial begin
      if (HOLE_POS >= W) $error("srq_mask_reg: HOLE_POS out of range");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == HOLE_POS) begin : g_hole
         assign mask_o[b] = 1'b0;
      end else begin : g_flop
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= 1'b0;
            else if (wr_i) q <= wdata_i[b];
         end
         assign mask_o[b] = q;
      end
   end
endmodule

// File: rtl/srq_byte_build.sv
module srq_byte_build
   import srq_pkg::*;
#(
   parameter int unsigned W = SB_W
) (
   input  srq_flags_t   flags_i,
   input  logic [W-1:0] mask_i,
   input  logic         req_i,
   output logic         msum_o,
   output logic [W-1:0] query_o,
   output logic [W-1:0] poll_o
);
   initial begin
      if (W != 8) $error("srq_byte_build: byte width must be 8");
   end

   logic [W-1:0] base;

   always_comb begin
      base           = '0;
      base[POS_ERR]  = flags_i.err;
      base[POS_EXT]  = flags_i.ext;
      base[POS_OUTQ] = flags_i.outq;
      base[POS_STD]  = flags_i.std;
   end

   assign msum_o = |(base & mask_i);

   always_comb begin
      query_o          = base;
      query_o[POS_SUM] = msum_o;
      poll_o           = base;
      poll_o[POS_SUM]  = req_i;
   end
endmodule

// File: rtl/srq_req_latch.sv
module srq_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic msum_i,
   input  logic poll_i,
   output logic req_o
);
   logic msum_q;
   logic rise;

   assign rise = msum_i & ~msum_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msum_q <= 1'b0;
         req_o  <= 1'b0;
      end else begin
         msum_q <= msum_i;
         if (rise)                 req_o <= 1'b1;
         else if (poll_i | ~msum_i) req_o <= 1'b0;
      end
   end
endmodule

// File: rtl/srq_status_gen.sv
module srq_status_gen
   import srq_pkg::*;
#(
   parameter int unsigned BYTE_W = SB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_pending_i,
   input  logic              out_pending_i,
   input  logic              ext_sum_i,
   input  logic              std_sum_i,
   input  logic              mask_wr_i,
   input  logic [BYTE_W-1:0] mask_wdata_i,
   output logic [BYTE_W-1:0] mask_rdata_o,
   input  logic              poll_i,
   output logic [BYTE_W-1:0] poll_byte_o,
   output logic [BYTE_W-1:0] query_byte_o,
   output logic              srq_o
);
   initial begin
      if (BYTE_W != SB_W) $error("srq_status_gen: BYTE_W must equal SB_W");
   end

   srq_flags_t        flags;
   logic [BYTE_W-1:0] mask;
   logic              msum;
   logic              req;

   assign flags = '{err: err_pending_i, outq: out_pending_i,
                    ext: ext_sum_i, std: std_sum_i};

   srq_mask_reg #(.W(BYTE_W), .HOLE_POS(POS_SUM)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_i(mask_wr_i),
      .wdata_i(mask_wdata_i), .mask_o(mask)
   );

   srq_byte_build #(.W(BYTE_W)) u_build (
      .flags_i(flags), .mask_i(mask), .req_i(req),
      .msum_o(msum), .query_o(query_byte_o), .poll_o(poll_byte_o)
   );

   srq_req_latch u_req (
      .clk(clk), .rst_n(rst_n), .msum_i(msum),
      .poll_i(poll_i), .req_o(req)
   );

   assign mask_rdata_o = mask;
   assign srq_o        = req;
endmodule

// File: rtl/srq_status_gen_chk.sv
module srq_status_gen_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              err_pending_i,
   input logic              out_pending_i,
   input logic              ext_sum_i,
   input logic              std_sum_i,
   input logic              mask_wr_i,
   input logic [BYTE_W-1:0] mask_wdata_i,
   input logic [BYTE_W-1:0] mask_rdata_o,
   input logic              poll_i,
   input logic [BYTE_W-1:0] poll_byte_o,
   input logic [BYTE_W-1:0] query_byte_o,
   input logic              srq_o
);
   // R1
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (query_byte_o[7] | query_byte_o[1] | query_byte_o[0] |
       poll_byte_o[7]  | poll_byte_o[1]  | poll_byte_o[0]) == 1'b0);

   // R2
   flag_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      query_byte_o[5:2] == {std_sum_i, out_pending_i, ext_sum_i, err_pending_i});

   // R4
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr_i |=> mask_rdata_o == ($past(mask_wdata_i) & 8'hBF));

   // R5
   req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(query_byte_o[6]) |=> srq_o);

   // R6
   poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_i && !$rose(query_byte_o[6])) |=> !srq_o);

   // R7
   sum_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !query_byte_o[6] |=> !srq_o);
endmodule

bind srq_status_gen srq_status_gen_chk #(.BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/srq_status_gen_tb.sv
`timescale 1ns/1ps
module srq_status_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       err_i = 0, outq_i = 0, ext_i = 0, std_i = 0;
   logic       wr = 0, poll = 0;
   logic [7:0] wdata = 0;
   logic [7:0] rdata, pbyte, qbyte;
   logic       srq;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   logic [7:0] m_mask = 0;
   logic       m_req = 0, m_prev = 0;

   always #2.5 clk = ~clk;

   srq_status_gen dut_i (
      .clk(clk), .rst_n(rst_n),
      .err_pending_i(err_i), .out_pending_i(outq_i),
      .ext_sum_i(ext_i), .std_sum_i(std_i),
      .mask_wr_i(wr), .mask_wdata_i(wdata), .mask_rdata_o(rdata),
      .poll_i(poll), .poll_byte_o(pbyte), .query_byte_o(qbyte), .srq_o(srq)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] base_byte();
      return {2'b00, std_i, outq_i, ext_i, err_i, 2'b00};
   endfunction

   // drive at negedge, check before posedge, advance model at posedge
   task automatic step(input logic [3:0] f, input logic p,
                       input logic w, input logic [7:0] d, input bit full);
      logic [7:0] b;
      logic       ms;
      @(negedge clk);
      {std_i, outq_i, ext_i, err_i} = f;
      poll = p; wr = w; wdata = d;
      #1;
      b  = base_byte();
      ms = |(b & m_mask);
      if (full) begin
         check("R1/R2/R3 query byte", qbyte, b | {1'b0, ms, 6'b0});
         check("R1/R2/R9 poll byte", pbyte, b | {1'b0, m_req, 6'b0});
         check("R4 mask readback", rdata, m_mask);
         check("R5 srq", {7'b0, srq}, {7'b0, m_req});
      end
      @(posedge clk);
      if (ms && !m_prev)    m_req = 1'b1;
      else if (p || !ms)    m_req = 1'b0;
      m_prev = ms;
      if (w) m_mask = d & 8'hBF;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10
      check("R10 mask after reset", rdata, 8'h00);
      check("R10 srq after reset", {7'b0, srq}, 8'h00);
      rst_n = 1'b1;

      // full sweep: every mask value, every flag pattern
      for (int m = 0; m < 256; m++) begin
         step(4'h0, 1'b0, 1'b1, m[7:0], 1);
         for (int f = 0; f < 16; f++) step(f[3:0], (f % 5) == 0, 1'b0, 8'h00, 1);
      end

      // R4 bit 6 readback
      step(4'h0, 0, 1, 8'hFF, 1);
      step(4'h0, 0, 0, 8'h00, 0);
      check("R4 bit6 forced 0", rdata, 8'hBF);

      // R11: only ext enabled; err/out/std toggled must not request
      step(4'h0, 0, 1, 8'h08, 1);
      step(4'h0, 0, 0, 8'h00, 1);
      step(4'b1101, 0, 0, 8'h00, 1);
      check("R11 masked flags no summary", {7'b0, qbyte[6]}, 8'h00);
      step(4'b1101, 0, 0, 8'h00, 1);
      check("R11 masked flags no srq", {7'b0, srq}, 8'h00);

      // R5 then R9/R6: rise, poll
      step(4'b0010, 0, 0, 8'h00, 1);   // ext rises
      step(4'b0010, 0, 0, 8'h00, 1);
      check("R5 srq after rise", {7'b0, srq}, 8'h01);
      step(4'b0010, 1, 0, 8'h00, 1);   // poll
      check("R9 poll byte bit6 during poll", {7'b0, pbyte[6]}, 8'h01);
      step(4'b0010, 0, 0, 8'h00, 1);
      check("R6 srq after poll", {7'b0, srq}, 8'h00);

      // R7: rise then summary falls
      step(4'b0000, 0, 0, 8'h00, 1);
      step(4'b0010, 0, 0, 8'h00, 1);
      step(4'b0000, 0, 0, 8'h00, 1);
      check("R7 set before fall", {7'b0, srq}, 8'h01);
      step(4'b0000, 0, 0, 8'h00, 1);
      check("R7 srq after fall", {7'b0, srq}, 8'h00);

      // R8: poll coincides with rise
      step(4'b0010, 1, 0, 8'h00, 1);
      step(4'b0010, 0, 0, 8'h00, 1);
      check("R8 set wins over poll", {7'b0, srq}, 8'h01);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule